// File: doc/BRIEF.md
# SPI Host Word-to-Byte Queue Bridge

This block sits between a 32-bit register port and the byte-wide transmit and receive queues of an SPI host. A transmit-word write splits the word into four bytes and enqueues them lowest byte first. The shift engine, which is not part of this block, drains the transmit queue one byte at a time through a head-byte port and a pop strobe. It fills the receive queue one byte at a time through a push strobe. A receive-word read dequeues up to four bytes and packs them into a word, lowest byte first.

The block keeps the queue flags and depth fields that software reads from the status word. It also keeps two sticky error flags: overflow, when a transmit write does not fit, and underflow, when a receive read runs dry. Each queue has a flush input that empties it. A ready flag is set when a transmit write is accepted in full, and the transfer side clears it with a strobe.

Top module: `spi_word_byte_bridge`

## Requirements
- R1: A transmit write enqueues wr_data[7:0] first, then [15:8], [23:16] and [31:24]. `tx_byte` shows the oldest byte whenever `tx_avail` is 1. A `tx_pop` while the queue is empty is ignored.
- R2: A transmit write that finds fewer than four free bytes enqueues only as many bytes as fit, in the order of R1, and drops the rest. One cycle later status bit 29 (transmit full) and `err_overflow` are both 1.
- R3: A transmit write that fits completely clears status bit 28 (transmit empty) and sets status bit 31 (ready). `ready_clr` clears the ready bit, and a write that is accepted in the same cycle wins over the clear.
- R4: A receive read clears status bit 25 (receive full) and dequeues bytes into rx_rd_data[7:0], [15:8], [23:16] and [31:24] in that order. `rx_rd_valid` pulses and `rx_rd_data` updates one cycle after the read.
- R5: A receive read that finds fewer than four bytes returns the bytes it has in the low lanes and zero in the upper lanes. One cycle later status bit 24 (receive empty) and `err_underflow` are both 1, unless a byte is pushed in the same cycle, which clears the empty bit.
- R6: A flush of a queue empties it, clears its full bit and sets its empty bit one cycle later. Any write, read, push or pop on that queue in the same cycle has no effect on it.
- R7: A receive push while the receive queue holds RX_DEPTH bytes drops the byte and sets status bit 25. An accepted push clears status bit 24.
- R8: Status bits 7:0 hold ceil(transmit bytes / 4) and bits 15:8 hold ceil(receive bytes / 4). Bit 22 (byte order, 0 for lowest byte first), bit 30 (active) and all other unnamed bits read 0.
- R9: An enqueue and a dequeue on the same queue in the same cycle both take effect. Fullness is judged on the occupancy before that cycle.
- R10: `err_overflow` and `err_underflow` stay set until `err_clr[0]` or `err_clr[1]` respectively is asserted. A new error in the same cycle as its clear keeps the flag set.
- R11: After reset both queues are empty, status is 32'h1100_0000, both error flags are 0, and `tx_avail` and `rx_rd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Transmit word write strobe |
| tx_wr_data | input | 32 | Transmit word |
| tx_flush | input | 1 | Empty the transmit queue |
| tx_pop | input | 1 | Shift engine takes the head transmit byte |
| tx_byte | output | 8 | Head transmit byte |
| tx_avail | output | 1 | Transmit queue holds at least one byte |
| rx_rd_en | input | 1 | Receive word read strobe |
| rx_rd_data | output | 32 | Packed receive word, valid with rx_rd_valid |
| rx_rd_valid | output | 1 | Read data returned, one cycle after rx_rd_en |
| rx_flush | input | 1 | Empty the receive queue |
| rx_push | input | 1 | Shift engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ready_clr | input | 1 | Clear the ready status bit |
| err_clr | input | 2 | Clear overflow (bit 0) or underflow (bit 1) |
| status | output | 32 | Status word (see R2 to R8) |
| err_overflow | output | 1 | Sticky transmit overflow error |
| err_underflow | output | 1 | Sticky receive underflow error |

## Verification
The assertions assume that every strobe is a clean level sampled on the rising edge. They also assume that the shift engine may pop or push in any cycle, including into an empty or full queue, because the block must tolerate that traffic rather than have it excluded. The bench drives each input from a single task at the falling edge, so that a strobe never changes near the active edge. It mixes directed fills to exactly full and empty with two random phases biased toward filling and toward draining. This carries both queues across their boundaries many times, with the flush inputs and error clears firing rarely.

// File: rtl/spi_wq_pkg.sv
package spi_wq_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_LANE = 4;
  localparam int WORD_W    = BYTE_W * WORD_LANE;

  // status word bit positions
  localparam int ST_TXQ_LSB  = 0;
  localparam int ST_RXQ_LSB  = 8;
  localparam int ST_ORDER    = 22;
  localparam int ST_RXEMPTY  = 24;
  localparam int ST_RXFULL   = 25;
  localparam int ST_TXEMPTY  = 28;
  localparam int ST_TXFULL   = 29;
  localparam int ST_ACTIVE   = 30;
  localparam int ST_READY    = 31;

  // depth field: bytes expressed in words, rounded up
  function automatic logic [7:0] ceil_words(input logic [31:0] n);
    logic [31:0] w;
    w = (n + 32'd3) >> 2;
    return w[7:0];
  endfunction
endpackage

// File: rtl/wq_byte_queue.sv
module wq_byte_queue #(
  parameter int DEPTH     = 256,
  parameter int IN_LANES  = 4,
  parameter int OUT_LANES = 1,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(IN_LANES + 1),
  localparam int OW = $clog2(OUT_LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [IW-1:0]          push_cnt,
  input  logic [IN_LANES*8-1:0]  push_data,
  input  logic [OW-1:0]          pop_cnt,
  output logic [OUT_LANES*8-1:0] peek,
  output logic [CW-1:0]          count
);
  localparam logic [PW:0] DV = (PW+1)'(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] base,
                                             input logic [31:0] off);
    logic [PW:0] s;
    s = {1'b0, base} + (PW+1)'(off);
    if (s >= DV) s = s - DV;
    return s[PW-1:0];
  endfunction

  always_comb begin : nxt
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      rd_d  = wrap_add(rd_q, 32'(pop_cnt));
      wr_d  = wrap_add(wr_q, 32'(push_cnt));
      cnt_d = cnt_q + CW'(push_cnt) - CW'(pop_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : regs
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin : store
    for (int k = 0; k < IN_LANES; k++) begin
      if (!flush && (32'(k) < 32'(push_cnt)))
        mem_q[wrap_add(wr_q, 32'(k))] <= push_data[k*8 +: 8];
    end
  end

  always_comb begin : head
    for (int k = 0; k < OUT_LANES; k++)
      peek[k*8 +: 8] = mem_q[wrap_add(rd_q, 32'(k))];
  end

  assign count = cnt_q;
endmodule

// File: rtl/wq_tx_side.sv
module wq_tx_side #(
  parameter int DEPTH = 288,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          pop,
  input  logic          ready_clr,
  output logic [7:0]    head,
  output logic          avail,
  output logic [CW-1:0] count,
  output logic          full_q,
  output logic          empty_q,
  output logic          ready_q,
  output logic          ovf_evt
);
  logic [CW-1:0] room;
  logic [2:0]    push_n;
  logic [0:0]    pop_n;
  logic          ok_evt, full_d, empty_d, ready_d;

  wq_byte_queue #(.DEPTH(DEPTH), .IN_LANES(4), .OUT_LANES(1)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_cnt(push_n), .push_data(wr_data),
    .pop_cnt(pop_n), .peek(head), .count(count)
  );

  always_comb begin : ctl
    room    = CW'(DEPTH) - count;
    ok_evt  = wr_en && !flush && (room >= CW'(4));
    ovf_evt = wr_en && !flush && (room <  CW'(4));
    push_n  = ok_evt ? 3'd4 : (ovf_evt ? 3'(room) : 3'd0);
    pop_n   = pop && !flush && (count != '0);
    full_d  = full_q;
    empty_d = empty_q;
    ready_d = ready_q;
    if (flush) begin
      full_d  = 1'b0;
      empty_d = 1'b1;
    end else begin
      if (ovf_evt) full_d  = 1'b1;
      if (ok_evt)  empty_d = 1'b0;
    end
    if (ready_clr) ready_d = 1'b0;
    if (ok_evt)    ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin : flags
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ready_q <= 1'b0;
    end else begin
      full_q  <= full_d;
      empty_q <= empty_d;
      ready_q <= ready_d;
    end
  end

  assign avail = (count != '0);
endmodule

// File: rtl/wq_rx_side.sv
module wq_rx_side #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          rd_en,
  input  logic          push,
  input  logic [7:0]    push_byte,
  output logic [31:0]   rd_data_q,
  output logic          rd_valid_q,
  output logic [CW-1:0] count,
  output logic          full_q,
  output logic          empty_q,
  output logic          unf_evt
);
  logic [31:0] peek, packed_w, rd_data_d;
  logic [2:0]  pop_n;
  logic [0:0]  push_n;
  logic        acc, drop, full_d, empty_d;

  wq_byte_queue #(.DEPTH(DEPTH), .IN_LANES(1), .OUT_LANES(4)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_cnt(push_n), .push_data(push_byte),
    .pop_cnt(pop_n), .peek(peek), .count(count)
  );

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign packed_w[k*8 +: 8] = (3'(k) < pop_n) ? peek[k*8 +: 8] : 8'h00;
  end

  always_comb begin : ctl
    unf_evt   = rd_en && !flush && (count < CW'(4));
    pop_n     = (!rd_en || flush) ? 3'd0 : (unf_evt ? 3'(count) : 3'd4);
    acc       = push && !flush && (count <  CW'(DEPTH));
    drop      = push && !flush && (count >= CW'(DEPTH));
    push_n    = acc;
    rd_data_d = rd_en ? packed_w : rd_data_q;
    full_d    = full_q;
    empty_d   = empty_q;
    if (flush) begin
      full_d  = 1'b0;
      empty_d = 1'b1;
    end else begin
      if (rd_en)   full_d  = 1'b0;
      if (drop)    full_d  = 1'b1;
      if (unf_evt) empty_d = 1'b1;
      if (acc)     empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin : regs
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      full_q     <= 1'b0;
      empty_q    <= 1'b1;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_en;
      full_q     <= full_d;
      empty_q    <= empty_d;
    end
  end
endmodule

// File: rtl/spi_word_byte_bridge.sv
module spi_word_byte_bridge
  import spi_wq_pkg::*;
#(
  parameter int TX_DEPTH = 288,
  parameter int RX_DEPTH = 256,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_wr_en,
  input  logic [31:0] tx_wr_data,
  input  logic        tx_flush,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_avail,
  input  logic        rx_rd_en,
  output logic [31:0] rx_rd_data,
  output logic        rx_rd_valid,
  input  logic        rx_flush,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        ready_clr,
  input  logic [1:0]  err_clr,
  output logic [31:0] status,
  output logic        err_overflow,
  output logic        err_underflow
);
  logic [TCW-1:0] tx_count;
  logic [RCW-1:0] rx_count;
  logic tx_full, tx_empty, ready, ovf_evt;
  logic rx_full, rx_empty, unf_evt;
  logic ovf_d, unf_d, ovf_q, unf_q;

  wq_tx_side #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .wr_en(tx_wr_en),
    .wr_data(tx_wr_data), .pop(tx_pop), .ready_clr(ready_clr),
    .head(tx_byte), .avail(tx_avail), .count(tx_count),
    .full_q(tx_full), .empty_q(tx_empty), .ready_q(ready), .ovf_evt(ovf_evt)
  );

  wq_rx_side #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .rd_en(rx_rd_en),
    .push(rx_push), .push_byte(rx_byte), .rd_data_q(rx_rd_data),
    .rd_valid_q(rx_rd_valid), .count(rx_count),
    .full_q(rx_full), .empty_q(rx_empty), .unf_evt(unf_evt)
  );

  always_comb begin : err_nxt
    ovf_d = ovf_evt | (ovf_q & ~err_clr[0]);
    unf_d = unf_evt | (unf_q & ~err_clr[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin : err_regs
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_comb begin : stat
    status = '0;
    status[ST_TXQ_LSB +: 8] = ceil_words(32'(tx_count));
    status[ST_RXQ_LSB +: 8] = ceil_words(32'(rx_count));
    status[ST_ORDER]   = 1'b0;
    status[ST_RXEMPTY] = rx_empty;
    status[ST_RXFULL]  = rx_full;
    status[ST_TXEMPTY] = tx_empty;
    status[ST_TXFULL]  = tx_full;
    status[ST_ACTIVE]  = 1'b0;
    status[ST_READY]   = ready;
  end

  assign err_overflow  = ovf_q;
  assign err_underflow = unf_q;
endmodule

// File: rtl/wq_bridge_chk.sv
module wq_bridge_chk #(
  parameter int TX_DEPTH = 288,
  parameter int RX_DEPTH = 256,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tx_wr_en,
  input logic           tx_flush,
  input logic           tx_pop,
  input logic           rx_rd_en,
  input logic           rx_flush,
  input logic           rx_push,
  input logic [1:0]     err_clr,
  input logic [31:0]    status,
  input logic           err_overflow,
  input logic           err_underflow,
  input logic           rx_rd_valid,
  input logic [31:0]    rx_rd_data,
  input logic [TCW-1:0] tx_count,
  input logic [RCW-1:0] rx_count
);
  // R2
  tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_en && !tx_flush && (32'(tx_count) > TX_DEPTH - 4)) |=> (err_overflow && status[29]));

  // R3
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_en && !tx_flush && (32'(tx_count) <= TX_DEPTH - 4)) |=> (status[31] && !status[28]));

  // R6
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> ((tx_count == '0) && status[28] && !status[29]));

  // R6
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> ((rx_count == '0) && status[24] && !status[25]));

  // R5
  rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_en && !rx_flush && !rx_push && (32'(rx_count) < 4)) |=> (err_underflow && status[24]));

  // R5
  rx_dry_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_en && (rx_count == '0)) |=> (rx_rd_valid && (rx_rd_data == 32'h0)));

  // R9
  tx_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_en && tx_pop && !tx_flush && (tx_count != '0) && (32'(tx_count) <= TX_DEPTH - 4))
    |=> (tx_count == $past(tx_count) + TCW'(3)));

  // R9
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_count) <= TX_DEPTH) && (32'(rx_count) <= RX_DEPTH));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overflow && !err_clr[0]) |=> err_overflow);

  // R10
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_underflow && !err_clr[1]) |=> err_underflow);
endmodule

bind spi_word_byte_bridge wq_bridge_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_flush(tx_flush), .tx_pop(tx_pop),
  .rx_rd_en(rx_rd_en), .rx_flush(rx_flush), .rx_push(rx_push), .err_clr(err_clr),
  .status(status), .err_overflow(err_overflow), .err_underflow(err_underflow),
  .rx_rd_valid(rx_rd_valid), .rx_rd_data(rx_rd_data),
  .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/spi_word_byte_bridge_tb.sv
`timescale 1ns/1ps
module spi_word_byte_bridge_tb;
  localparam int TXD = 288;
  localparam int RXD = 256;

  logic clk, rst_n;
  logic tx_wr_en, tx_flush, tx_pop, rx_rd_en, rx_flush, rx_push, ready_clr;
  logic [31:0] tx_wr_data, rx_rd_data, status;
  logic [7:0]  tx_byte, rx_byte;
  logic [1:0]  err_clr;
  logic tx_avail, rx_rd_valid, err_overflow, err_underflow;

  spi_word_byte_bridge #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
    .tx_flush(tx_flush), .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_rd_valid(rx_rd_valid),
    .rx_flush(rx_flush), .rx_push(rx_push), .rx_byte(rx_byte),
    .ready_clr(ready_clr), .err_clr(err_clr), .status(status),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic        wr;
    logic [31:0] wdata;
    logic        tpop;
    logic        tflush;
    logic        rd;
    logic        rpush;
    logic [7:0]  rbyte;
    logic        rflush;
    logic        rclr;
    logic [1:0]  eclr;
  } stim_t;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] tq[$];
  logic [7:0] rq[$];
  logic m_tfull, m_tempty, m_ready, m_rfull, m_rempty, m_ovf, m_unf, m_valid;
  logic [31:0] m_rdata;

  function automatic stim_t idle();
    stim_t s;
    s.wr = 0; s.wdata = '0; s.tpop = 0; s.tflush = 0; s.rd = 0;
    s.rpush = 0; s.rbyte = '0; s.rflush = 0; s.rclr = 0; s.eclr = '0;
    return s;
  endfunction

  function automatic logic [7:0] words(input int n);
    return 8'((n + 3) / 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R8 tx depth field", 32'(status[7:0]), 32'(words(tq.size())));
    chk("R8 rx depth field", 32'(status[15:8]), 32'(words(rq.size())));
    chk("R8 zero bits", {status[23:16], status[27:26], status[30]}, '0);
    chk("R3 tx empty bit", 32'(status[28]), 32'(m_tempty));
    chk("R3 ready bit", 32'(status[31]), 32'(m_ready));
    chk("R2 tx full bit", 32'(status[29]), 32'(m_tfull));
    chk("R7 rx full bit", 32'(status[25]), 32'(m_rfull));
    chk("R5 rx empty bit", 32'(status[24]), 32'(m_rempty));
    chk("R2 overflow flag", 32'(err_overflow), 32'(m_ovf));
    chk("R5 underflow flag", 32'(err_underflow), 32'(m_unf));
    chk("R4 read valid", 32'(rx_rd_valid), 32'(m_valid));
    if (m_valid) chk("R4 read data", rx_rd_data, m_rdata);
    chk("R1 tx avail", 32'(tx_avail), 32'(tq.size() > 0));
    if (tq.size() > 0) chk("R1 tx head byte", 32'(tx_byte), 32'(tq[0]));
  endtask

  task automatic step(input stim_t s);
    int tsz, rsz, room, n;
    logic ovf_set, unf_set, rdy_set;
    logic [31:0] d;
    @(negedge clk);
    tx_wr_en = s.wr; tx_wr_data = s.wdata; tx_pop = s.tpop; tx_flush = s.tflush;
    rx_rd_en = s.rd; rx_push = s.rpush; rx_byte = s.rbyte; rx_flush = s.rflush;
    ready_clr = s.rclr; err_clr = s.eclr;
    tsz = tq.size(); rsz = rq.size();
    ovf_set = 0; unf_set = 0; rdy_set = 0;
    if (s.tflush) begin
      tq.delete(); m_tfull = 0; m_tempty = 1;
    end else begin
      room = TXD - tsz;
      if (s.tpop && tsz > 0) void'(tq.pop_front());
      if (s.wr) begin
        n = (room < 4) ? room : 4;
        for (int k = 0; k < n; k++) tq.push_back(s.wdata[k*8 +: 8]);
        if (room < 4) begin m_tfull = 1; ovf_set = 1; end
        else begin m_tempty = 0; rdy_set = 1; end
      end
    end
    if (rdy_set) m_ready = 1; else if (s.rclr) m_ready = 0;
    m_valid = s.rd;
    if (s.rflush) begin
      rq.delete(); m_rfull = 0; m_rempty = 1;
      if (s.rd) m_rdata = '0;
    end else begin
      if (s.rd) begin
        m_rfull = 0; d = '0;
        n = (rsz < 4) ? rsz : 4;
        for (int k = 0; k < n; k++) d[k*8 +: 8] = rq.pop_front();
        m_rdata = d;
        if (rsz < 4) begin m_rempty = 1; unf_set = 1; end
      end
      if (s.rpush) begin
        if (rsz < RXD) begin rq.push_back(s.rbyte); m_rempty = 0; end
        else m_rfull = 1;
      end
    end
    m_ovf = ovf_set | (m_ovf & ~s.eclr[0]);
    m_unf = unf_set | (m_unf & ~s.eclr[1]);
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic rand_phase(input int cycles, input int p_wr, input int p_pop,
                            input int p_rd, input int p_push);
    stim_t s;
    for (int i = 0; i < cycles; i++) begin
      s = idle();
      s.wr     = ($urandom % 100) < p_wr;
      s.wdata  = $urandom;
      s.tpop   = ($urandom % 100) < p_pop;
      s.rd     = ($urandom % 100) < p_rd;
      s.rpush  = ($urandom % 100) < p_push;
      s.rbyte  = 8'($urandom);
      s.tflush = ($urandom % 400) == 0;
      s.rflush = ($urandom % 400) == 0;
      s.rclr   = ($urandom % 100) < 20;
      s.eclr   = (($urandom % 100) < 10) ? 2'($urandom) : 2'b00;
      step(s);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    stim_t s;
    void'($urandom(32'd12345));
    rst_n = 0;
    tx_wr_en = 0; tx_wr_data = '0; tx_pop = 0; tx_flush = 0;
    rx_rd_en = 0; rx_push = 0; rx_byte = '0; rx_flush = 0;
    ready_clr = 0; err_clr = '0;
    m_tfull = 0; m_tempty = 1; m_ready = 0; m_rfull = 0; m_rempty = 1;
    m_ovf = 0; m_unf = 0; m_valid = 0; m_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    // R11 reset state
    chk("R11 reset status", status, 32'h1100_0000);
    chk("R11 reset errors", {30'b0, err_overflow, err_underflow}, 32'h0);
    chk("R11 reset tx_avail and valid", {30'b0, tx_avail, rx_rd_valid}, 32'h0);

    // R1 byte order on transmit
    s = idle(); s.wr = 1; s.wdata = 32'h4433_2211; step(s);
    chk("R1 first byte", 32'(tx_byte), 32'h11);
    s = idle(); s.tpop = 1; step(s);
    chk("R1 second byte", 32'(tx_byte), 32'h22);
    // R9 write and pop together: 3 + 4 - 1 = 6 bytes, 2 words
    s = idle(); s.wr = 1; s.wdata = 32'h8877_6655; s.tpop = 1; step(s);
    chk("R9 same cycle depth", 32'(status[7:0]), 32'd2);
    chk("R9 head after pop", 32'(tx_byte), 32'h33);
    s = idle(); s.tpop = 1; step(s); step(s);
    // R3 ready cleared
    s = idle(); s.rclr = 1; step(s);
    chk("R3 ready cleared", 32'(status[31]), 32'd0);
    // R6 flush overrides a write
    s = idle(); s.tflush = 1; s.wr = 1; s.wdata = 32'hDEAD_BEEF; step(s);
    chk("R6 tx flush", {status[7:0], status[29:28]}, 32'h001);
    chk("R6 tx avail", 32'(tx_avail), 32'd0);

    // R2 fill to full, then overflow part way
    for (int i = 0; i < TXD / 4; i++) begin
      s = idle(); s.wr = 1; s.wdata = 32'($urandom); step(s);
    end
    chk("R2 full no overflow", 32'(err_overflow), 32'd0);
    s = idle(); s.tpop = 1; step(s); step(s);
    s = idle(); s.wr = 1; s.wdata = 32'hA3A2_A1A0; step(s);
    chk("R2 overflow raised", {status[29], err_overflow}, 32'h3);
    chk("R2 depth after partial", 32'(status[7:0]), 32'(TXD / 4));
    // R10 clear and clear with new event
    s = idle(); s.eclr = 2'b01; step(s);
    chk("R10 overflow cleared", 32'(err_overflow), 32'd0);
    s = idle(); s.wr = 1; s.eclr = 2'b01; step(s);
    chk("R10 event beats clear", 32'(err_overflow), 32'd1);
    for (int i = 0; i < TXD; i++) begin
      s = idle(); s.tpop = 1; step(s);
    end

    // R5 partial read
    s = idle(); s.rflush = 1; step(s);
    s = idle(); s.rpush = 1; s.rbyte = 8'hAA; step(s);
    s.rbyte = 8'hBB; step(s);
    s.rbyte = 8'hCC; step(s);
    s = idle(); s.rd = 1; step(s);
    chk("R5 partial word", rx_rd_data, 32'h00CC_BBAA);
    chk("R5 underflow and empty", {status[24], err_underflow}, 32'h3);
    // R7 / R4 fill receive queue beyond full
    for (int i = 0; i <= RXD; i++) begin
      s = idle(); s.rpush = 1; s.rbyte = 8'(i); step(s);
    end
    chk("R7 rx full set", 32'(status[25]), 32'd1);
    s = idle(); s.rd = 1; step(s);
    chk("R4 full cleared by read", 32'(status[25]), 32'd0);
    chk("R4 packed word", rx_rd_data, 32'h0302_0100);
    s = idle(); s.rflush = 1; s.rpush = 1; step(s);
    chk("R6 rx flush", {status[15:8], status[25:24]}, 32'h001);
    s = idle(); s.eclr = 2'b11; step(s);

    rand_phase(1500, 60, 20, 15, 70);
    rand_phase(1500, 20, 60, 50, 30);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule